// File: doc/BRIEF.md
# Two-Wire Register Slave with 16-bit Words

This block is a target on a two-wire serial bus. Through it an external controller reads and writes a small file of 16-bit control registers. The bus lines are sampled on the system clock through synchronizers. The block pulls the data line low through an open-drain enable. It never drives the line high.

A transaction opens with a start condition and a device byte. The block answers only to its own seven-bit address. After a write-direction device byte, the next byte loads an 8-bit register pointer. The bytes after that are taken in pairs, high byte first, and each complete pair is committed to the register the pointer selects. To read, the controller first writes the pointer and then issues a repeated start with the read-direction device byte. The block then returns words high byte first, for as long as the controller acknowledges each byte. The pointer advances by one after every complete word in both directions.

The rest of the chip sees the file through a parallel port. A registered lookup returns any register by index, and a one-cycle pulse reports each committed write. Register 0 holds a fixed identification value and cannot be written.

Top module: `twr_regslave`

## Requirements
- R1: The device byte 0xBA (7-bit address 0x5D, bit 0 = 0) selects write and 0xBB (bit 0 = 1) selects read. Either is acknowledged by pulling SDA low during the ninth clock. Any other device byte is not acknowledged, and the block ignores the bus until the next start.
- R2: A start (SDA falls while SCL is high) or a stop (SDA rises while SCL is high) is recognised in any state. One cycle after either, `sda_oe` is low.
- R3: In a write, the first byte after the device byte is the register pointer. Each following pair of bytes forms one word, high byte first and MSB first. The block acknowledges the pointer and every data byte. A register changes only after both bytes of its word have arrived.
- R4: `sda_oe` changes only while the synchronized SCL is low, except for its release on a start or stop.
- R5: The pointer advances by one after each complete 16-bit word, in writes and in reads. It wraps modulo 256.
- R6: A read is a pointer write followed by a repeated start with 0xBB. The block sends the addressed word high byte first, MSB first. A controller ACK continues with the next byte. A NACK ends the read, and the block leaves SDA released until the next start.
- R7: Register 0 reads 0x8431 on the bus and on the host port. Bus writes to it are dropped and produce no write pulse.
- R8: Pointer values from NUM_REGS (16) to 255 address no register. Writes to them are dropped, and reads of them return 0x0000.
- R9: A start or stop that arrives after the high byte of a word but before its low byte discards that half word. No register changes.
- R10: After reset, every writable register is 0x0000, `sda_oe` is low and `wr_pulse` is low.
- R11: `cfg_data` shows the register selected by `cfg_addr` one cycle after `cfg_addr` is applied. Each committed word raises `wr_pulse` for exactly one cycle, with its index on `wr_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_addr | input | $clog2(NUM_REGS) | Host lookup index |
| cfg_data | output | 16 | Registered lookup result |
| wr_pulse | output | 1 | One-cycle pulse per committed word |
| wr_index | output | $clog2(NUM_REGS) | Index of the committed register |

## Verification
The assertions assume a well-behaved controller. Each high and low phase of SCL must last several system clocks, so that the synchronized edges stay apart. SDA may change only while SCL is low, except at a start or stop. No start or stop may arrive while the block is driving a data bit. The bench controller holds every quarter of a bit period for six system clocks. It changes SDA only in the low phase and issues starts and stops only when SDA is released. Random pointers and word counts cover the edges of the register file and the range beyond it.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_PTR,
    PH_WR,
    PH_RD
  } phase_t;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/twr_linemon.sv
module twr_linemon (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic p_scl, p_sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_scl <= 1'b1;
      p_sda <= 1'b1;
    end else begin
      p_scl <= scl_s;
      p_sda <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~p_scl;
  assign scl_fall = ~scl_s & p_scl;
  assign ev_start = scl_s & p_scl & p_sda & ~sda_s;
  assign ev_stop  = scl_s & p_scl & ~p_sda & sda_s;
endmodule

// File: rtl/twr_regfile.sv
module twr_regfile #(
  parameter int NUM_REGS = 16,
  parameter logic [15:0] CHIP_ID = 16'h8431,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [15:0]      wdata,
  input  logic [7:0]       pidx,
  output logic [15:0]      pdata,
  input  logic [IDX_W-1:0] hidx,
  output logic [15:0]      hdata
);
  localparam logic [8:0] NREG9 = 9'(NUM_REGS);

  logic [15:0] mem [NUM_REGS];

  function automatic logic [15:0] fetch(input logic [7:0] idx);
    if (idx == 8'd0) return CHIP_ID;
    if ({1'b0, idx} < NREG9) return mem[idx[IDX_W-1:0]];
    return 16'h0000;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= 16'h0000;
    end else if (we && widx != '0) begin
      mem[widx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    hdata <= fetch(8'(hidx));
  end

  assign pdata = fetch(pidx);
endmodule

// File: rtl/twr_regslave.sv
module twr_regslave
  import twr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h5D,
  parameter int          NUM_REGS = 16,
  parameter logic [15:0] CHIP_ID = 16'h8431,
  parameter int          SYNC_STAGES = 2,
  localparam int         IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [IDX_W-1:0] cfg_addr,
  output logic [15:0]      cfg_data,
  output logic             wr_pulse,
  output logic [IDX_W-1:0] wr_index
);
  localparam logic [8:0] NREG9 = 9'(NUM_REGS);

  logic [1:0] lines_s;
  logic scl_q, sda_q;
  logic scl_rise, scl_fall, ev_start, ev_stop;

  twr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(lines_s)
  );
  assign scl_q = lines_s[1];
  assign sda_q = lines_s[0];

  twr_linemon u_mon (
    .clk(clk), .rst(rst), .scl_s(scl_q), .sda_s(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  phase_t      ph;
  logic        in_ack, hi_done, rd_pend, load_req, nack, oe;
  logic [3:0]  cnt;
  logic [7:0]  sh, hold_hi, ptr;
  logic [15:0] tx, pdata, rf_wdata;
  logic        rf_we;
  logic [IDX_W-1:0] rf_widx;

  function automatic logic writable(input logic [7:0] p);
    return (p != 8'd0) && ({1'b0, p} < NREG9);
  endfunction

  twr_regfile #(.NUM_REGS(NUM_REGS), .CHIP_ID(CHIP_ID)) u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .pidx(ptr), .pdata(pdata),
    .hidx(cfg_addr), .hdata(cfg_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      in_ack   <= 1'b0;
      hi_done  <= 1'b0;
      rd_pend  <= 1'b0;
      load_req <= 1'b0;
      nack     <= 1'b0;
      oe       <= 1'b0;
      cnt      <= 4'd0;
      sh       <= 8'd0;
      hold_hi  <= 8'd0;
      ptr      <= 8'd0;
      tx       <= 16'd0;
      rf_we    <= 1'b0;
      rf_widx  <= '0;
      rf_wdata <= 16'd0;
    end else begin
      rf_we    <= 1'b0;
      load_req <= 1'b0;
      if (ev_start) begin
        ph      <= PH_DEV;
        in_ack  <= 1'b0;
        cnt     <= 4'd0;
        hi_done <= 1'b0;
        oe      <= 1'b0;
      end else if (ev_stop) begin
        ph      <= PH_IDLE;
        in_ack  <= 1'b0;
        cnt     <= 4'd0;
        hi_done <= 1'b0;
        oe      <= 1'b0;
      end else if (load_req) begin
        tx <= {pdata[14:0], 1'b0};
        oe <= ~pdata[15];
      end else begin
        case (ph)
          PH_DEV, PH_PTR, PH_WR: begin
            if (!in_ack && scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_q};
              cnt <= cnt + 4'd1;
            end else if (!in_ack && scl_fall && cnt == 4'd8) begin
              cnt <= 4'd0;
              case (ph)
                PH_DEV: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    in_ack  <= 1'b1;
                    oe      <= 1'b1;
                    rd_pend <= sh[0];
                  end else begin
                    ph <= PH_IDLE;
                  end
                end
                PH_PTR: begin
                  ptr    <= sh;
                  in_ack <= 1'b1;
                  oe     <= 1'b1;
                end
                default: begin
                  in_ack <= 1'b1;
                  oe     <= 1'b1;
                  if (!hi_done) begin
                    hold_hi <= sh;
                    hi_done <= 1'b1;
                  end else begin
                    hi_done <= 1'b0;
                    ptr     <= ptr + 8'd1;
                    if (writable(ptr)) begin
                      rf_we    <= 1'b1;
                      rf_widx  <= ptr[IDX_W-1:0];
                      rf_wdata <= {hold_hi, sh};
                    end
                  end
                end
              endcase
            end else if (in_ack && scl_fall) begin
              in_ack <= 1'b0;
              oe     <= 1'b0;
              if (ph == PH_DEV) begin
                if (rd_pend) begin
                  ph       <= PH_RD;
                  hi_done  <= 1'b0;
                  load_req <= 1'b1;
                end else begin
                  ph <= PH_PTR;
                end
              end else if (ph == PH_PTR) begin
                ph <= PH_WR;
              end
            end
          end
          PH_RD: begin
            if (!in_ack && scl_rise && cnt < 4'd8) begin
              cnt <= cnt + 4'd1;
            end else if (!in_ack && scl_fall) begin
              if (cnt == 4'd8) begin
                oe     <= 1'b0;
                in_ack <= 1'b1;
                cnt    <= 4'd0;
              end else begin
                oe <= ~tx[15];
                tx <= {tx[14:0], 1'b0};
              end
            end else if (in_ack && scl_rise) begin
              nack <= sda_q;
            end else if (in_ack && scl_fall) begin
              in_ack <= 1'b0;
              if (nack) begin
                ph <= PH_IDLE;
              end else if (!hi_done) begin
                hi_done <= 1'b1;
                oe      <= ~tx[15];
                tx      <= {tx[14:0], 1'b0};
              end else begin
                hi_done  <= 1'b0;
                ptr      <= ptr + 8'd1;
                load_req <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe   = oe;
  assign wr_pulse = rf_we;
  assign wr_index = rf_widx;
endmodule

// File: rtl/twr_regslave_chk.sv
module twr_regslave_chk #(
  parameter int NUM_REGS = 16,
  parameter logic [15:0] CHIP_ID = 16'h8431,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe,
  input logic             scl_q,
  input logic             ev_start,
  input logic             ev_stop,
  input logic [IDX_W-1:0] cfg_addr,
  input logic [15:0]      cfg_data,
  input logic             wr_pulse,
  input logic [IDX_W-1:0] wr_index
);
  AST_COND_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ev_start || ev_stop) |=> !sda_oe); // R2

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(ev_start) && !$past(ev_stop)) |-> !$past(scl_q)); // R4

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse); // R11

  AST_WR_NOT_ID: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> (wr_index != '0)); // R7

  AST_ID_HOST: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_addr) == '0) |-> (cfg_data == CHIP_ID)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && !wr_pulse)); // R10
endmodule

bind twr_regslave twr_regslave_chk #(.NUM_REGS(NUM_REGS), .CHIP_ID(CHIP_ID)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_q(scl_q),
  .ev_start(ev_start), .ev_stop(ev_stop),
  .cfg_addr(cfg_addr), .cfg_data(cfg_data),
  .wr_pulse(wr_pulse), .wr_index(wr_index)
);

// File: tb/sim_twr_regslave.sv
module sim_twr_regslave;
  localparam int NR = 16;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_pulse;
  logic [3:0] cfg_addr = 4'd0, wr_index;
  logic [15:0] cfg_data;
  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  twr_regslave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .wr_pulse(wr_pulse), .wr_index(wr_index)
  );

  int unsigned tests = 0, fails = 0, pulses = 0, exp_pulses = 0;
  logic [15:0] model [NR];
  logic [15:0] wbuf [4];

  always @(posedge clk) if (!rst && wr_pulse) pulses++;

  function automatic logic [15:0] exp_val(input logic [7:0] p);
    if (p == 8'd0) return 16'h8431;
    if (p < 8'(NR)) return model[p[3:0]];
    return 16'h0000;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_line}; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_write(input logic [7:0] p, input int n, input string req);
    logic a, all_ack;
    logic [7:0] idx;
    bus_start();
    send_byte(8'hBA, all_ack);
    send_byte(p, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i][15:8], a); all_ack &= a;
      send_byte(wbuf[i][7:0], a); all_ack &= a;
      idx = p + 8'(i);
      if (idx != 8'd0 && idx < 8'(NR)) begin
        model[idx[3:0]] = wbuf[i];
        exp_pulses++;
      end
    end
    bus_stop();
    chk({31'd0, all_ack}, 32'd1, req);
  endtask

  task automatic bus_read(input logic [7:0] p, input int n, input string req);
    logic a;
    logic [7:0] hi, lo;
    bus_start();
    send_byte(8'hBA, a);
    send_byte(p, a);
    bus_start();
    send_byte(8'hBB, a);
    chk({31'd0, a}, 32'd1, {req, " R1 read address ack"});
    for (int i = 0; i < n; i++) begin
      recv_byte(1'b1, hi);
      recv_byte(i != n - 1, lo);
      chk({16'd0, hi, lo}, {16'd0, exp_val(p + 8'(i))}, req);
    end
    bus_stop();
  endtask

  task automatic host_chk(input logic [3:0] idx, input string req);
    cfg_addr = idx; tick(2);
    chk({16'd0, cfg_data}, {16'd0, exp_val({4'd0, idx})}, req);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic a;
    logic [7:0] b;
    void'($urandom(32'h5EED));
    for (int i = 0; i < NR; i++) model[i] = 16'h0000;
    tick(6); rst = 1'b0; tick(2);

    // R10 reset state
    chk({31'd0, sda_oe}, 32'd0, "R10 sda_oe after reset");
    chk({31'd0, wr_pulse}, 32'd0, "R10 wr_pulse after reset");
    for (int i = 1; i < NR; i++) host_chk(4'(i), "R10 register reset value");
    host_chk(4'd0, "R7 id on host port");

    // R3 single word, R11 host view and pulse
    wbuf[0] = 16'hBEEF;
    bus_write(8'd3, 1, "R3 write acks");
    host_chk(4'd3, "R11 host read after write");
    bus_read(8'd3, 1, "R6 read single word");

    // R5 burst with auto increment
    wbuf[0] = 16'h1111; wbuf[1] = 16'h2222; wbuf[2] = 16'h3333;
    bus_write(8'd5, 3, "R5 burst write acks");
    host_chk(4'd5, "R5 burst word 0");
    host_chk(4'd6, "R5 burst word 1");
    host_chk(4'd7, "R5 burst word 2");
    bus_read(8'd5, 3, "R5 R6 burst read");

    // R7 writes to id register dropped
    wbuf[0] = 16'h0BAD;
    bus_write(8'd0, 1, "R7 write to id acked");
    bus_read(8'd0, 1, "R7 id over bus");
    chk(pulses, exp_pulses, "R7 no pulse for id write");

    // R8 beyond the file
    wbuf[0] = 16'hCAFE; wbuf[1] = 16'hF00D;
    bus_write(8'd20, 2, "R8 out of range write acked");
    chk(pulses, exp_pulses, "R8 no pulse out of range");
    bus_read(8'd14, 4, "R8 read across end of file");

    // R1 foreign address ignored
    bus_start();
    send_byte(8'hBC, a);
    chk({31'd0, a}, 32'd0, "R1 foreign address not acked");
    send_byte(8'd3, a);
    send_byte(8'h55, a);
    send_byte(8'h66, a);
    chk({31'd0, a}, 32'd0, "R1 later bytes not acked");
    bus_stop();
    host_chk(4'd3, "R1 register untouched");

    // R9 half word discarded by stop, then by repeated start
    bus_start(); send_byte(8'hBA, a); send_byte(8'd7, a); send_byte(8'h12, a);
    bus_stop();
    host_chk(4'd7, "R9 half word dropped at stop");
    bus_start(); send_byte(8'hBA, a); send_byte(8'd7, a); send_byte(8'h34, a);
    bus_start(); send_byte(8'hBA, a); send_byte(8'd8, a);
    send_byte(8'hA5, a); send_byte(8'h5A, a);
    bus_stop();
    model[8] = 16'hA55A; exp_pulses++;
    host_chk(4'd7, "R9 half word dropped at restart");
    host_chk(4'd8, "R9 word after restart");

    // R6 after NACK the line stays released
    bus_start(); send_byte(8'hBA, a); send_byte(8'd3, a);
    bus_start(); send_byte(8'hBB, a);
    recv_byte(1'b1, b); recv_byte(1'b0, b);
    recv_byte(1'b0, b);
    chk({24'd0, b}, 32'h000000FF, "R6 released after NACK");
    bus_stop();

    // random traffic, R3 R5 R6
    for (int it = 0; it < 14; it++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom_range(0, 17));
      n = int'($urandom_range(1, 3));
      for (int k = 0; k < 4; k++) wbuf[k] = 16'($urandom());
      bus_write(p, n, "R3 random write acks");
      p = 8'($urandom_range(0, 17));
      bus_read(p, int'($urandom_range(1, 3)), "R6 random read");
      host_chk(4'($urandom_range(0, 15)), "R11 random host read");
    end

    chk(pulses, exp_pulses, "R11 commit pulse count");
    report();
  end
endmodule